// File: doc/BRIEF.md
# Exception Entry Sequencer

This block runs the entry half of exception handling for a small 32-bit core. Four sources can ask for entry: a maskable interrupt held as a level by an external controller, a non-maskable interrupt, a software break and a bus fault. The last three arrive as single-cycle pulses and are latched as pending. When the sequencer is idle it picks one acceptable request and takes a snapshot of the core state it needs. It then works out the new architectural state and presents it on a register-file update port for one cycle.

After the update cycle the sequencer issues one word read of the handler address from a vector table. The table sits at a base address supplied by the core, with one 4-byte entry per vector number. When the word returns, the sequencer acknowledges the entry and hands the word back as the new program counter. Only one entry runs at a time. Pulses that arrive during a sequence stay pending until it ends, except a bus fault raised while the handler address is being fetched, which is dropped.

Top module: `exc_seq_top`

## Requirements
- R1: Among acceptable requests the priority is bus fault, then break, then non-maskable interrupt, then maskable interrupt. A pulse that arrives while a sequence runs, or that is not yet acceptable, stays pending and is taken later. `ack_kind` reports 0 for the maskable interrupt, 1 for the non-maskable interrupt, 2 for break and 3 for bus fault.
- R2: The maskable interrupt is taken only when status bit 5 (interrupt enable) is 1 and `irq_locked` is 0. It uses `irq_vec` and writes the return address through `upd_erp_we`.
- R3: The non-maskable interrupt is taken only when its mask flag is 1. That flag is status bit 9 when `core_ver` is below 32 and status bit 30 otherwise. The entry uses vector 0, clears that flag before the status transform and writes the return address through `upd_nrp_we` only.
- R4: A break uses `trap_vec` and a bus fault uses `bfault_vec`. Both write the return address through `upd_erp_we`.
- R5: `upd_exs` carries the vector number in bits 15:8 and zero in every other bit.
- R6: When `in_dslot` is 1 the return address is `core_pc - dslot_off` and `upd_dslot_clr` is 1. Otherwise the return address is `core_pc` and `upd_dslot_clr` is 0.
- R7: When status bit 6 (user mode) is 1, `upd_sp_swap` is 1, `upd_usp` equals `core_sp` and `upd_sp` equals `core_ksp`. Otherwise `upd_sp_swap` is 0.
- R8: The new status keeps old bits 31:30, places old bits 19:0 in bits 29:10 and sets bits 9:0 to zero.
- R9: The sequence order is fixed. The update cycle comes first. In the next cycle comes a one-cycle `mem_rd` at `core_ebp + 4*vector`. The cycle after `mem_rvalid` is seen brings `ack`, with `pc_new` equal to the returned word and `ack_vec` equal to the vector.
- R10: A `bfault_req` pulse that arrives while the handler fetch is outstanding starts no entry. The pending bit of a completed entry is cleared, so the same request is not taken twice.
- R11: During and after reset, `busy`, `upd_valid`, `mem_rd` and `ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Maskable interrupt request level |
| irq_vec | input | 8 | Vector from the interrupt controller |
| nmi_req | input | 1 | Non-maskable interrupt pulse |
| brk_req | input | 1 | Break pulse |
| trap_vec | input | 8 | Programmed break vector |
| bfault_req | input | 1 | Bus fault pulse |
| bfault_vec | input | 8 | Fault vector from the translation unit |
| core_pc | input | 32 | Current program counter |
| core_sr | input | 32 | Current status register |
| core_sp | input | 32 | Current stack pointer |
| core_ksp | input | 32 | Kernel stack pointer |
| core_ebp | input | 32 | Vector table base |
| core_ver | input | 8 | Architecture version |
| irq_locked | input | 1 | Interrupt lock flag |
| in_dslot | input | 1 | Core is in a branch delay slot |
| dslot_off | input | 2 | Delay-slot back-up offset |
| busy | output | 1 | A sequence is running |
| upd_valid | output | 1 | Register update strobe |
| upd_erp_we | output | 1 | Write return address to the exception return register |
| upd_nrp_we | output | 1 | Write return address to the NMI return register |
| upd_ret | output | 32 | Return address |
| upd_exs | output | 32 | Exception status value |
| upd_sr | output | 32 | New status value |
| upd_sp_swap | output | 1 | Write the stack pointer and the user stack pointer |
| upd_sp | output | 32 | New stack pointer |
| upd_usp | output | 32 | New user stack pointer |
| upd_dslot_clr | output | 1 | Clear the delay-slot state |
| mem_rd | output | 1 | Handler address read request |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| ack | output | 1 | Entry done; load `pc_new` |
| ack_kind | output | 2 | Source of the completed entry |
| ack_vec | output | 8 | Vector of the completed entry |
| pc_new | output | 32 | Handler address |

## Verification
The assertions check the cycle order of update, fetch and acknowledge on every cycle. They also check the zero fields of the exception status and status values, that exactly one return register is written, and that a non-maskable entry always reports vector 0. The bench scenarios are needed for the rest. They show the choice among simultaneous requests and that blocked requests stay held. They compare the exact return address, stack swap, status transform and fetch address against independently computed values for each source. They also show that a bus fault raised during the fetch, and an entry already completed, lead to no further entry.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
    localparam int XLEN      = 32;
    localparam int VEC_W     = 8;
    localparam int VER_W     = 8;
    localparam int I_BIT     = 5;
    localparam int U_BIT     = 6;
    localparam int M_BIT_OLD = 9;
    localparam int M_BIT_NEW = 30;
    localparam int VER_SPLIT = 32;
    localparam int SR_SHIFT  = 10;
    localparam int SR_KEEP   = 2;
    localparam int EXS_POS   = 8;
    localparam int N_PEND    = 3;

    typedef enum logic [2:0] {
        S_IDLE, S_UPDATE, S_FETCH_REQ, S_FETCH_WAIT, S_DONE
    } seq_st_e;

    typedef enum logic [1:0] {
        K_IRQ = 2'd0, K_NMI = 2'd1, K_BRK = 2'd2, K_BFAULT = 2'd3
    } exc_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] ret;
        logic [XLEN-1:0] sr;
        logic [XLEN-1:0] exs;
        logic            swap;
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] usp;
        logic [XLEN-1:0] addr;
        logic            dclr;
    } frame_t;

    function automatic int m_flag_pos(input logic [VER_W-1:0] ver);
        return (int'(ver) < VER_SPLIT) ? M_BIT_OLD : M_BIT_NEW;
    endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_seq_pkg::*;
(
    input  logic [N_PEND-1:0] pend,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [VEC_W-1:0]  trap_vec,
    input  logic [VEC_W-1:0]  bfault_vec,
    input  logic [XLEN-1:0]   sr,
    input  logic [VER_W-1:0]  ver,
    input  logic              irq_locked,
    output logic              take,
    output exc_kind_e         kind,
    output logic [VEC_W-1:0]  vec
);
    logic nmi_ok;
    logic irq_ok;

    always_comb begin
        nmi_ok = pend[0] && sr[m_flag_pos(ver)];
        irq_ok = irq_req && sr[I_BIT] && !irq_locked;
        take   = 1'b1;
        kind   = K_IRQ;
        vec    = irq_vec;
        if (pend[2]) begin
            kind = K_BFAULT;
            vec  = bfault_vec;
        end else if (pend[1]) begin
            kind = K_BRK;
            vec  = trap_vec;
        end else if (nmi_ok) begin
            kind = K_NMI;
            vec  = '0;
        end else if (!irq_ok) begin
            take = 1'b0;
        end
    end
endmodule

// File: rtl/exc_frame.sv
module exc_frame
    import exc_seq_pkg::*;
#(
    parameter int DOFF_W = 2
) (
    input  exc_kind_e         kind,
    input  logic [VEC_W-1:0]  vec,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   sr,
    input  logic [XLEN-1:0]   sp,
    input  logic [XLEN-1:0]   ksp,
    input  logic [XLEN-1:0]   ebp,
    input  logic [VER_W-1:0]  ver,
    input  logic              in_dslot,
    input  logic [DOFF_W-1:0] dslot_off,
    output frame_t            frame
);
    localparam int LOW_KEEP = XLEN - SR_KEEP - SR_SHIFT;

    logic [XLEN-1:0] sr_m;

    always_comb begin
        sr_m = sr;
        if (kind == K_NMI) begin
            sr_m[m_flag_pos(ver)] = 1'b0;
        end
        frame.sr   = {sr_m[XLEN-1 -: SR_KEEP], sr_m[LOW_KEEP-1:0], {SR_SHIFT{1'b0}}};
        frame.ret  = in_dslot ? (pc - XLEN'(dslot_off)) : pc;
        frame.dclr = in_dslot;
        frame.exs  = XLEN'(vec) << EXS_POS;
        frame.swap = sr[U_BIT];
        frame.sp   = ksp;
        frame.usp  = sp;
        frame.addr = ebp + (XLEN'(vec) << 2);
    end
endmodule

// File: rtl/exc_seq_top.sv
module exc_seq_top
    import exc_seq_pkg::*;
#(
    parameter int DOFF_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              nmi_req,
    input  logic              brk_req,
    input  logic [VEC_W-1:0]  trap_vec,
    input  logic              bfault_req,
    input  logic [VEC_W-1:0]  bfault_vec,
    input  logic [XLEN-1:0]   core_pc,
    input  logic [XLEN-1:0]   core_sr,
    input  logic [XLEN-1:0]   core_sp,
    input  logic [XLEN-1:0]   core_ksp,
    input  logic [XLEN-1:0]   core_ebp,
    input  logic [VER_W-1:0]  core_ver,
    input  logic              irq_locked,
    input  logic              in_dslot,
    input  logic [DOFF_W-1:0] dslot_off,
    output logic              busy,
    output logic              upd_valid,
    output logic              upd_erp_we,
    output logic              upd_nrp_we,
    output logic [XLEN-1:0]   upd_ret,
    output logic [XLEN-1:0]   upd_exs,
    output logic [XLEN-1:0]   upd_sr,
    output logic              upd_sp_swap,
    output logic [XLEN-1:0]   upd_sp,
    output logic [XLEN-1:0]   upd_usp,
    output logic              upd_dslot_clr,
    output logic              mem_rd,
    output logic [XLEN-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              ack,
    output logic [1:0]        ack_kind,
    output logic [VEC_W-1:0]  ack_vec,
    output logic [XLEN-1:0]   pc_new
);
    typedef struct packed {
        seq_st_e           st;
        exc_kind_e         kind;
        logic [VEC_W-1:0]  vec;
        frame_t            fr;
        logic [XLEN-1:0]   pc;
        logic [N_PEND-1:0] pend;
    } seq_t;

    seq_t q, d;

    logic             arb_take;
    exc_kind_e        arb_kind;
    logic [VEC_W-1:0] arb_vec;
    frame_t           frame;
    logic             fetching;

    exc_arbiter u_arb (
        .pend       (q.pend),
        .irq_req    (irq_req),
        .irq_vec    (irq_vec),
        .trap_vec   (trap_vec),
        .bfault_vec (bfault_vec),
        .sr         (core_sr),
        .ver        (core_ver),
        .irq_locked (irq_locked),
        .take       (arb_take),
        .kind       (arb_kind),
        .vec        (arb_vec)
    );

    exc_frame #(.DOFF_W(DOFF_W)) u_frame (
        .kind      (arb_kind),
        .vec       (arb_vec),
        .pc        (core_pc),
        .sr        (core_sr),
        .sp        (core_sp),
        .ksp       (core_ksp),
        .ebp       (core_ebp),
        .ver       (core_ver),
        .in_dslot  (in_dslot),
        .dslot_off (dslot_off),
        .frame     (frame)
    );

    assign fetching = (q.st == S_FETCH_REQ) || (q.st == S_FETCH_WAIT);

    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: begin
                if (arb_take) begin
                    d.kind = arb_kind;
                    d.vec  = arb_vec;
                    d.fr   = frame;
                    d.st   = S_UPDATE;
                end
            end
            S_UPDATE:    d.st = S_FETCH_REQ;
            S_FETCH_REQ: d.st = S_FETCH_WAIT;
            S_FETCH_WAIT: begin
                if (mem_rvalid) begin
                    d.pc = mem_rdata;
                    d.st = S_DONE;
                end
            end
            S_DONE: begin
                case (q.kind)
                    K_NMI:    d.pend[0] = 1'b0;
                    K_BRK:    d.pend[1] = 1'b0;
                    K_BFAULT: d.pend[2] = 1'b0;
                    default:  ;
                endcase
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
        d.pend = d.pend | {bfault_req && !fetching, brk_req, nmi_req};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy          = (q.st != S_IDLE);
    assign upd_valid     = (q.st == S_UPDATE);
    assign upd_erp_we    = upd_valid && (q.kind != K_NMI);
    assign upd_nrp_we    = upd_valid && (q.kind == K_NMI);
    assign upd_ret       = q.fr.ret;
    assign upd_exs       = q.fr.exs;
    assign upd_sr        = q.fr.sr;
    assign upd_sp_swap   = upd_valid && q.fr.swap;
    assign upd_sp        = q.fr.sp;
    assign upd_usp       = q.fr.usp;
    assign upd_dslot_clr = upd_valid && q.fr.dclr;
    assign mem_rd        = (q.st == S_FETCH_REQ);
    assign mem_addr      = q.fr.addr;
    assign ack           = (q.st == S_DONE);
    assign ack_kind      = q.kind;
    assign ack_vec       = q.vec;
    assign pc_new        = q.pc;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
    import exc_seq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             upd_valid,
    input logic             upd_erp_we,
    input logic             upd_nrp_we,
    input logic [XLEN-1:0]  upd_exs,
    input logic [XLEN-1:0]  upd_sr,
    input logic             mem_rd,
    input logic             mem_rvalid,
    input logic             ack,
    input logic [1:0]       ack_kind,
    input logic [VEC_W-1:0] ack_vec
);
    assert_fetch_follows_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> mem_rd);
    assert_ack_after_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(mem_rvalid));
    assert_single_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({upd_valid, mem_rd, ack}));
    assert_phase_implies_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid || mem_rd || ack) |-> busy);
    assert_nmi_vector_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_kind == 2'd1) |-> (ack_vec == '0));
    assert_one_return_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_erp_we != upd_nrp_we));
    assert_exs_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_exs[7:0] == '0 && upd_exs[XLEN-1:16] == '0));
    assert_exs_matches_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (upd_exs[15:8] == ack_vec));
    assert_sr_low_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_sr[9:0] == '0));
endmodule

bind exc_seq_top exc_seq_chk u_chk (.*);

// File: tb/test_exc_seq_top.sv
module test_exc_seq_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_req, nmi_req, brk_req, bfault_req;
    logic [7:0]  irq_vec, trap_vec, bfault_vec, core_ver;
    logic [31:0] core_pc, core_sr, core_sp, core_ksp, core_ebp;
    logic        irq_locked, in_dslot;
    logic [1:0]  dslot_off;
    logic        busy, upd_valid, upd_erp_we, upd_nrp_we, upd_sp_swap, upd_dslot_clr;
    logic [31:0] upd_ret, upd_exs, upd_sr, upd_sp, upd_usp, mem_addr, mem_rdata, pc_new;
    logic        mem_rd, mem_rvalid, ack;
    logic [1:0]  ack_kind;
    logic [7:0]  ack_vec;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    exc_seq_top i_exc_seq_top (.*);

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int m_pos(input logic [7:0] ver);
        return (ver < 8'd32) ? 9 : 30;
    endfunction

    function automatic logic [31:0] exp_sr(input logic [31:0] sr, input int kind, input logic [7:0] ver);
        logic [31:0] s = sr;
        if (kind == 1) s[m_pos(ver)] = 1'b0;
        return {s[31:30], s[19:0], 10'b0};
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'hC3A5_0F1E;
    endfunction

    // Serve one entry sequence and check every output it produces.
    task automatic serve(input int ek, input logic [7:0] ev, input bit bf_glitch);
        int cnt = 0;
        int dly = -1;
        bit done = 0;
        logic [31:0] eaddr = core_ebp + {22'b0, ev, 2'b00};
        logic [31:0] eret = in_dslot ? core_pc - {30'b0, dslot_off} : core_pc;
        while (!done && cnt < 300) begin
            @(negedge clk);
            cnt++;
            mem_rvalid = 1'b0;
            bfault_req = 1'b0;
            if (upd_valid) begin
                chk("R2", "erp_we", {31'b0, upd_erp_we}, {31'b0, ek != 1});
                chk("R3", "nrp_we", {31'b0, upd_nrp_we}, {31'b0, ek == 1});
                chk("R5", "exs", upd_exs, {16'b0, ev, 8'b0});
                chk("R6", "ret", upd_ret, eret);
                chk("R6", "dslot_clr", {31'b0, upd_dslot_clr}, {31'b0, in_dslot});
                chk("R7", "swap", {31'b0, upd_sp_swap}, {31'b0, core_sr[6]});
                if (core_sr[6]) begin
                    chk("R7", "sp", upd_sp, core_ksp);
                    chk("R7", "usp", upd_usp, core_sp);
                end
                chk("R8", "sr", upd_sr, exp_sr(core_sr, ek, core_ver));
            end
            if (mem_rd) begin
                chk("R9", "mem_addr", mem_addr, eaddr);
                dly = $urandom_range(0, 3);
                if (bf_glitch) bfault_req = 1'b1;
            end else if (dly == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_word(eaddr);
                dly = -1;
            end else if (dly > 0) begin
                dly--;
                if (bf_glitch) bfault_req = 1'b1;
            end
            if (ack) begin
                chk("R1", "ack_kind", {30'b0, ack_kind}, ek);
                chk("R4", "ack_vec", {24'b0, ack_vec}, {24'b0, ev});
                chk("R9", "pc_new", pc_new, mem_word(eaddr));
                if (ek == 0) irq_req = 1'b0;
                done = 1;
            end
        end
        if (!done) chk("R9", "ack seen", 32'd0, 32'd1);
    endtask

    task automatic idle_check(input string req, input int n);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy || upd_valid) seen = 1;
        end
        chk(req, "no entry", {31'b0, seen}, 32'd0);
    endtask

    task automatic pulse(input bit n, input bit b, input bit f);
        @(negedge clk);
        nmi_req = n; brk_req = b; bfault_req = f;
        @(negedge clk);
        nmi_req = 0; brk_req = 0; bfault_req = 0;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        process::self().srandom(32'd4242);
        rst_n = 0;
        {irq_req, nmi_req, brk_req, bfault_req, irq_locked, in_dslot, mem_rvalid} = '0;
        irq_vec = 8'h21; trap_vec = 8'h05; bfault_vec = 8'h0C; core_ver = 8'd40;
        core_pc = 32'h0000_4000; core_sr = '0; core_sp = 32'h0001_0000;
        core_ksp = 32'h0002_0000; core_ebp = 32'h0000_8000; dslot_off = 2'd2; mem_rdata = '0;
        repeat (3) @(negedge clk);
        chk("R11", "reset outputs", {28'b0, busy, upd_valid, mem_rd, ack}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R11", "idle after reset", {28'b0, busy, upd_valid, mem_rd, ack}, 32'd0);

        // R2: blocked by cleared enable, then by lock, then taken
        irq_req = 1;
        idle_check("R2", 10);
        core_sr = 32'h0000_0020; irq_locked = 1;
        idle_check("R2", 10);
        irq_locked = 0;
        serve(0, irq_vec, 0);
        idle_check("R10", 6);

        // R3: NMI held while legacy mask flag is clear, then taken
        core_ver = 8'd10; core_sr = 32'hC008_0040;
        pulse(1, 0, 0);
        idle_check("R3", 10);
        core_sr[9] = 1'b1;
        serve(1, 8'h00, 0);
        core_ver = 8'd40; core_sr = 32'h4000_0200;
        pulse(1, 0, 0);
        serve(1, 8'h00, 0);

        // R1: break beats NMI beats held interrupt
        core_sr = 32'h4000_0020;
        @(negedge clk); nmi_req = 1; brk_req = 1;
        @(negedge clk); nmi_req = 0; brk_req = 0; irq_req = 1;
        serve(2, trap_vec, 0);
        serve(1, 8'h00, 0);
        serve(0, irq_vec, 0);
        // R1: bus fault beats break
        pulse(0, 1, 1);
        serve(3, bfault_vec, 0);
        serve(2, trap_vec, 0);

        // R10: bus fault during the handler fetch is dropped
        in_dslot = 1; dslot_off = 2'd3;
        pulse(0, 1, 0);
        serve(2, trap_vec, 1);
        idle_check("R10", 12);

        // Random entries
        for (int t = 0; t < 60; t++) begin
            int k = $urandom_range(0, 3);
            logic [7:0] v;
            core_pc = $urandom; core_sr = $urandom; core_sp = $urandom;
            core_ksp = $urandom; core_ebp = $urandom; core_ver = 8'($urandom_range(0, 63));
            in_dslot = 1'($urandom); dslot_off = 2'($urandom);
            irq_vec = 8'($urandom); trap_vec = 8'($urandom); bfault_vec = 8'($urandom);
            irq_locked = 0;
            case (k)
                0: begin core_sr[5] = 1'b1; v = irq_vec; end
                1: begin core_sr[m_pos(core_ver)] = 1'b1; v = 8'h00; end
                2: v = trap_vec;
                default: v = bfault_vec;
            endcase
            if (k == 0) begin
                @(negedge clk); irq_req = 1;
            end else begin
                pulse(k == 1, k == 2, k == 3);
            end
            serve(k, v, 0);
            repeat (2) @(negedge clk);
        end
        finish_run();
    end
endmodule